// File: doc/BRIEF.md
# Edge Timing Error Monitor

This block sits beside the edge generation datapath of one tester channel and watches it without driving it. Each fast clock cycle it samples the load and finish events of four edge delay countdown counters, the sequence tags and finish strobes used to pair action codes with edges, the carry-outs of the residue and calibration adders, the delay values sent to the drive and compare verniers, and the per-edge and per-window fail flags of edges D0 to D3. Whenever one of these shows a fault, the block sets a sticky bit in an 8-bit status vector.

The status appears as a 16-bit read-only word at address 0. Software pulses a synchronous clear at the start of each pattern burst and reads the word during or after the burst to learn whether edges were lost or mistimed, and which edges failed. A read is a single-cycle request (`rd_en_i` with `rd_addr_i`). One cycle later it returns `rd_valid_o` with the data. The read path has no back-pressure: every request is answered on the next cycle, and a request can be issued every cycle.

Top module: `edge_mon`

## Requirements
- R1: The status word is 16 bits at address 0. Bits 15..8 always read 0, a read of any other address returns 0, and every status bit is 0 after reset.
- R2: Bit 7 (lost edge) is set when counter i gets a load (`cnt_load_i[i]`) while it is still counting, meaning it has been loaded and has not reported `cnt_done_i[i]` since.
- R3: Bit 6 (order fault) is set when two or more finish strobes (`fin_stb_i`) occur in one cycle, or when a single strobe carries a tag that differs from the expected tag. Counter i's tag is `fin_tag_i[2i+1:2i]`. The expected tag is 0 after reset and after a clear, and it advances (mod 4) by the number of strobes in each cycle.
- R4: Bit 5 (wrap) is set when the residue adder carry or the calibration adder carry is high.
- R5: Bit 4 (non-monotonic) is set when the drive vernier or the compare vernier has a valid delay in two consecutive cycles and the second value is less than or equal to the first.
- R6: A vernier delay that follows a cycle with no valid delay on that vernier is never flagged, whatever its value.
- R7: Bits 3..0 collect fails. Bit k is set by `edge_fail_i[k]` or `win_fail_i[k]`, where window flag 0 is the D0 window, flag 1 is the D0/D1 window, flag 2 is the D2 window and flag 3 is the D3/D2 window.
- R8: Status bits are sticky until `clr_i`. An event seen in the cycle after it appears at the next edge. In a clear cycle the clear wins, and all bits read 0 afterwards.
- R9: `rd_valid_o` is high exactly one cycle after `rd_en_i` is high. The data then holds the status as it stood when the request was sampled, before that cycle's events were added.
- R10: A load on a counting counter in the same cycle as that counter's `cnt_done_i` is a legal back-to-back reload and does not set bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of status and expected tag |
| cnt_load_i | input | 4 | Counter load events |
| cnt_done_i | input | 4 | Counter countdown finished |
| fin_stb_i | input | 4 | Counter finish strobes for order checking |
| fin_tag_i | input | 8 | 2-bit sequence tag per counter |
| res_carry_i | input | 1 | Residue adder carry-out |
| cal_carry_i | input | 1 | Calibration adder carry-out |
| drv_vld_i | input | 1 | Drive vernier delay valid |
| drv_dly_i | input | DLY_W | Drive vernier delay |
| cmp_vld_i | input | 1 | Compare vernier delay valid |
| cmp_dly_i | input | DLY_W | Compare vernier delay |
| edge_fail_i | input | 4 | Per-edge fail flags D0..D3 |
| win_fail_i | input | 4 | Window fail flags |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 16 | Read data |

## Verification
Corrupt internal state shows up only through the read port, as a status bit that is wrongly set or wrongly missing. With reads issued almost every cycle, it is caught at most two edges after the cycle that should have decided it. A busy flag stuck high or low, or an expected tag off by one, corrupts bit 7 or bit 6 only when the next load or strobe arrives, so the stimulus keeps those events frequent. A wrong vernier history shows on the next back-to-back valid pair. Clears are issued often so that sticky bits that are already set do not hide later errors.

// File: rtl/edge_mon_pkg.sv
package edge_mon_pkg;
  localparam int NUM_EDGE = 4;
  localparam int TAG_W    = $clog2(NUM_EDGE);
  localparam int STS_W    = 16;
  localparam int EVT_W    = 8;

  // packed order matches status bit positions 7..0
  typedef struct packed {
    logic             lost;
    logic             order;
    logic             wrap;
    logic             mono;
    logic [NUM_EDGE-1:0] fail;
  } evt_t;
endpackage

// File: rtl/edge_mon_reload.sv
module edge_mon_reload
  import edge_mon_pkg::*;
#(
  parameter int N = NUM_EDGE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] load_i,
  input  logic [N-1:0] done_i,
  output logic         err_o
);
  logic [N-1:0] busy_q;
  logic [N-1:0] early;

  for (genvar i = 0; i < N; i++) begin : g_cnt
    assign early[i] = load_i[i] & busy_q[i] & ~done_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy_q[i] <= 1'b0;
      else if (load_i[i]) busy_q[i] <= 1'b1;
      else if (done_i[i]) busy_q[i] <= 1'b0;
    end

    // R2: a load always leaves the counter counting
    a_r2_load_busy : assert property (@(posedge clk) disable iff (!rst_n)
      load_i[i] |=> busy_q[i]);
  end

  assign err_o = |early;

  // R10: a reload accompanied by done is never flagged
  a_r10_done_reload : assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> |(load_i & ~done_i));
endmodule

// File: rtl/edge_mon_order.sv
module edge_mon_order
  import edge_mon_pkg::*;
#(
  parameter int N  = NUM_EDGE,
  parameter int TW = TAG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic [N-1:0]    stb_i,
  input  logic [N*TW-1:0] tag_i,
  output logic            err_o
);
  localparam int CNT_W = $clog2(N + 1);

  logic [TW-1:0]    exp_q;
  logic [CNT_W-1:0] n_stb;
  logic [N-1:0]     bad;

  for (genvar i = 0; i < N; i++) begin : g_tag
    assign bad[i] = stb_i[i] & (tag_i[i*TW +: TW] != exp_q);
  end

  always_comb begin
    n_stb = '0;
    for (int i = 0; i < N; i++) n_stb = n_stb + CNT_W'(stb_i[i]);
  end

  assign err_o = (n_stb > CNT_W'(1)) | (|bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     exp_q <= '0;
    else if (clr_i) exp_q <= '0;
    else            exp_q <= exp_q + TW'(n_stb);
  end

  // R3: simultaneous completions always count as an order fault
  a_r3_multi : assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(stb_i) > 1) |-> err_o);
  // R3: no strobes, expected tag holds
  a_r3_tag_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i == '0 && !clr_i) |=> $stable(exp_q));
  // R8: clear restarts the tag sequence
  a_r8_tag_clr : assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> exp_q == '0);
endmodule

// File: rtl/edge_mon_vern.sv
module edge_mon_vern #(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             err_o
);
  logic             pv_q;
  logic [DLY_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q   <= 1'b0;
      last_q <= '0;
    end else begin
      pv_q <= vld_i;
      if (vld_i) last_q <= dly_i;
    end
  end

  assign err_o = vld_i & pv_q & (dly_i <= last_q);

  // R5: history follows every valid value
  a_r5_history : assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (pv_q && last_q == $past(dly_i)));
  // R6: after an idle cycle nothing is flagged
  a_r6_idle_skip : assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !err_o);
endmodule

// File: rtl/edge_mon.sv
module edge_mon
  import edge_mon_pkg::*;
#(
  parameter int DLY_W    = 12,
  parameter int ADDR_W   = 4,
  parameter int STS_ADDR = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_i,
  input  logic [NUM_EDGE-1:0]    cnt_load_i,
  input  logic [NUM_EDGE-1:0]    cnt_done_i,
  input  logic [NUM_EDGE-1:0]    fin_stb_i,
  input  logic [NUM_EDGE*TAG_W-1:0] fin_tag_i,
  input  logic                   res_carry_i,
  input  logic                   cal_carry_i,
  input  logic                   drv_vld_i,
  input  logic [DLY_W-1:0]       drv_dly_i,
  input  logic                   cmp_vld_i,
  input  logic [DLY_W-1:0]       cmp_dly_i,
  input  logic [NUM_EDGE-1:0]    edge_fail_i,
  input  logic [NUM_EDGE-1:0]    win_fail_i,
  input  logic                   rd_en_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic                   rd_valid_o,
  output logic [STS_W-1:0]       rd_data_o
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(STS_ADDR);

  logic lost_err, order_err, drv_err, cmp_err;
  evt_t evt, sts_q;
  logic rd_valid_q;
  logic [STS_W-1:0] rd_data_q;

  edge_mon_reload #(.N(NUM_EDGE)) u_reload (
    .clk(clk), .rst_n(rst_n), .load_i(cnt_load_i), .done_i(cnt_done_i),
    .err_o(lost_err));

  edge_mon_order #(.N(NUM_EDGE), .TW(TAG_W)) u_order (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .stb_i(fin_stb_i),
    .tag_i(fin_tag_i), .err_o(order_err));

  edge_mon_vern #(.DLY_W(DLY_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .vld_i(drv_vld_i), .dly_i(drv_dly_i),
    .err_o(drv_err));

  edge_mon_vern #(.DLY_W(DLY_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .vld_i(cmp_vld_i), .dly_i(cmp_dly_i),
    .err_o(cmp_err));

  always_comb begin
    evt       = '0;
    evt.lost  = lost_err;
    evt.order = order_err;
    evt.wrap  = res_carry_i | cal_carry_i;
    evt.mono  = drv_err | cmp_err;
    for (int k = 0; k < NUM_EDGE; k++) evt.fail[k] = edge_fail_i[k] | win_fail_i[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sts_q <= '0;
    else if (clr_i) sts_q <= '0;
    else            sts_q <= sts_q | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i)
        rd_data_q <= (rd_addr_i == SEL) ? {{(STS_W-EVT_W){1'b0}}, sts_q} : '0;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  // R1: unused upper bits never read as one
  a_r1_upper_zero : assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> rd_data_o[STS_W-1:EVT_W] == '0);
  // R9: one response per request, one cycle later
  a_r9_resp : assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);
  a_r9_no_resp : assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);
  // R8: without clear no bit ever drops
  a_r8_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
  a_r8_clear : assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> sts_q == '0);
  // R4: adder carry sets wrap bit
  a_r4_wrap : assert property (@(posedge clk) disable iff (!rst_n)
    ((res_carry_i || cal_carry_i) && !clr_i) |=> sts_q.wrap);
endmodule

// File: tb/sim_edge_mon.sv
`timescale 1ns/1ps
module sim_edge_mon;
  localparam int DW = 12;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr;
  logic [3:0] ld, dn, stb, ef, wf;
  logic [7:0] tag;
  logic rc, cc, dv, cv, rd_en;
  logic [DW-1:0] dd, cd;
  logic [AW-1:0] ra;
  logic rd_valid;
  logic [15:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  edge_mon #(.DLY_W(DW), .ADDR_W(AW), .STS_ADDR(0)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .cnt_load_i(ld), .cnt_done_i(dn),
    .fin_stb_i(stb), .fin_tag_i(tag), .res_carry_i(rc), .cal_carry_i(cc),
    .drv_vld_i(dv), .drv_dly_i(dd), .cmp_vld_i(cv), .cmp_dly_i(cd),
    .edge_fail_i(ef), .win_fail_i(wf), .rd_en_i(rd_en), .rd_addr_i(ra),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data));

  // behavioural reference
  bit [7:0] m_sts;
  bit       m_busy [4];
  int       m_tag;
  int       m_dlast, m_clast;
  bit       m_dpv, m_cpv;
  bit       e_vld;
  bit [15:0] e_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sts = 0; m_tag = 0; m_dpv = 0; m_cpv = 0; m_dlast = 0; m_clast = 0;
      foreach (m_busy[i]) m_busy[i] = 0;
      e_vld = 0; e_data = 0;
    end else begin
      bit lost, ord, mono;
      int n;
      e_vld = rd_en;
      if (rd_en) e_data = (ra == 0) ? {8'h00, m_sts} : 16'h0;
      lost = 0;
      for (int i = 0; i < 4; i++) begin
        if (ld[i] && m_busy[i] && !dn[i]) lost = 1;
        if (ld[i]) m_busy[i] = 1; else if (dn[i]) m_busy[i] = 0;
      end
      n = 0; ord = 0;
      for (int i = 0; i < 4; i++)
        if (stb[i]) begin
          n++;
          if (int'(tag[2*i +: 2]) != m_tag) ord = 1;
        end
      if (n > 1) ord = 1;
      m_tag = (m_tag + n) % 4;
      mono = 0;
      if (dv && m_dpv && int'(dd) <= m_dlast) mono = 1;
      if (cv && m_cpv && int'(cd) <= m_clast) mono = 1;
      if (dv) m_dlast = int'(dd);
      if (cv) m_clast = int'(cd);
      m_dpv = dv; m_cpv = cv;
      if (clr) begin
        m_sts = 0; m_tag = 0;
      end else
        m_sts = m_sts | {lost, ord, rc | cc, mono, ef | wf};
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_cmp++;
      if (rd_valid !== e_vld) begin
        n_bad++;
        $display("FAIL R9 valid: got %b expected %b", rd_valid, e_vld);
      end else if (e_vld && rd_data !== e_data) begin
        n_bad++;
        if (rd_data[15:8] !== e_data[15:8]) $display("FAIL R1 upper: got %h expected %h", rd_data, e_data);
        if (rd_data[7] !== e_data[7]) $display("FAIL R2/R10 lost bit: got %h expected %h", rd_data, e_data);
        if (rd_data[6] !== e_data[6]) $display("FAIL R3 order bit: got %h expected %h", rd_data, e_data);
        if (rd_data[5] !== e_data[5]) $display("FAIL R4 wrap bit: got %h expected %h", rd_data, e_data);
        if (rd_data[4] !== e_data[4]) $display("FAIL R5/R6 mono bit: got %h expected %h", rd_data, e_data);
        if (rd_data[3:0] !== e_data[3:0]) $display("FAIL R7 fail bits: got %h expected %h", rd_data, e_data);
      end
    end
  end

  task automatic idle();
    clr = 0; ld = 0; dn = 0; stb = 0; tag = 0; rc = 0; cc = 0;
    dv = 0; cv = 0; dd = 0; cd = 0; ef = 0; wf = 0; rd_en = 0; ra = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_clr();
    idle(); clr = 1; step(); idle(); step();
  endtask

  // explicit read and check, independent of the reference
  task automatic rd_chk(input logic [AW-1:0] a, input logic [15:0] mask,
                        input logic [15:0] val, input string req);
    idle(); rd_en = 1; ra = a; step(); idle();
    n_cmp++;
    if (!rd_valid || (rd_data & mask) !== val) begin
      n_bad++;
      $display("FAIL %s: got %h (valid %b) expected %h under mask %h",
               req, rd_data, rd_valid, val, mask);
    end
  endtask

  initial begin
    idle();
    repeat (3) step();
    rst_n = 1;
    step();
    rd_chk(0, 16'hFFFF, 16'h0000, "R1 reset state");

    // R10: reload with done on a counting counter is legal
    ld = 4'b0001; step(); idle();
    ld = 4'b0001; dn = 4'b0001; step(); idle();
    dn = 4'b0001; step(); idle(); step();
    rd_chk(0, 16'h0080, 16'h0000, "R10 done-reload");
    // R2: reload while counting
    ld = 4'b0100; step(); idle();
    ld = 4'b0100; step(); idle(); step();
    rd_chk(0, 16'h0080, 16'h0080, "R2 early reload");
    // R8: clear
    do_clr();
    rd_chk(0, 16'hFFFF, 16'h0000, "R8 clear");
    // R3: in-order tags pass, then two strobes at once
    stb = 4'b0010; tag = 8'b0000_0000; step(); idle();
    stb = 4'b1000; tag = 8'b0100_0000; step(); idle(); step();
    rd_chk(0, 16'h0040, 16'h0000, "R3 in order");
    stb = 4'b0011; tag = 8'b0000_1110; step(); idle(); step();
    rd_chk(0, 16'h0040, 16'h0040, "R3 simultaneous");
    do_clr();
    stb = 4'b0001; tag = 8'b0000_0011; step(); idle(); step();
    rd_chk(0, 16'h0040, 16'h0040, "R3 wrong tag");
    // R4
    do_clr();
    cc = 1; step(); idle(); step();
    rd_chk(0, 16'h0020, 16'h0020, "R4 calibration carry");
    // R6 then R5
    do_clr();
    dv = 1; dd = 12'd40; step(); idle(); step();
    dv = 1; dd = 12'd7; step(); idle(); step();
    rd_chk(0, 16'h0010, 16'h0000, "R6 idle gap");
    cv = 1; cd = 12'd9; step(); cv = 1; cd = 12'd9; step(); idle(); step();
    rd_chk(0, 16'h0010, 16'h0010, "R5 equal back-to-back");
    // R7
    do_clr();
    wf = 4'b0010; step(); idle(); ef = 4'b1000; step(); idle(); step();
    rd_chk(0, 16'h000F, 16'h000A, "R7 fail fold");
    rd_chk(3, 16'hFFFF, 16'h0000, "R1 other address");
    // R8: clear beats a same-cycle event
    idle(); clr = 1; rc = 1; step(); idle(); step();
    rd_chk(0, 16'hFFFF, 16'h0000, "R8 clear priority");

    // random traffic checked against the reference every cycle
    for (int c = 0; c < 6000; c++) begin
      idle();
      clr = ($urandom_range(0, 15) == 0);
      for (int i = 0; i < 4; i++) begin
        ld[i] = ($urandom_range(0, 9) == 0);
        dn[i] = ($urandom_range(0, 9) < 4);
      end
      case ($urandom_range(0, 29))
        0: stb = 4'b0101;
        1, 2, 3, 4, 5, 6, 7, 8: begin
          int w;
          w = $urandom_range(0, 3);
          stb[w] = 1;
          tag[2*w +: 2] = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'(m_tag);
        end
        default: ;
      endcase
      rc = ($urandom_range(0, 49) == 0);
      cc = ($urandom_range(0, 49) == 0);
      dv = ($urandom_range(0, 9) < 7);
      cv = ($urandom_range(0, 9) < 7);
      dd = ($urandom_range(0, 19) == 0) ? DW'(m_dlast) : DW'(m_dlast + $urandom_range(1, 4));
      cd = ($urandom_range(0, 19) == 0) ? DW'(m_clast - 1) : DW'(m_clast + $urandom_range(1, 4));
      ef = ($urandom_range(0, 29) == 0) ? 4'($urandom) : 4'h0;
      wf = ($urandom_range(0, 29) == 0) ? 4'($urandom) : 4'h0;
      rd_en = ($urandom_range(0, 9) < 8);
      ra = ($urandom_range(0, 9) == 0) ? AW'($urandom) : '0;
      step();
    end
    idle(); step(); step();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule